// File: doc/BRIEF.md
# Triggered Input Capture Channel

This block timestamps transitions on a single input pin. A free-running internal counter advances on a selectable tick: one of five timer ticks, or every clock. When a qualifying edge is seen on the pin, the counter's current value is written into a small capture queue. Software reads the queue from its head. An interrupt pulse tells software that a chosen number of captures has been stored.

The counter has two control modes. In triggered mode it is held at zero until a chosen event source fires, and a status bit then shows that it is running. In synchronized mode it runs freely, and a chosen event source clears it to zero each time that source fires. The event source is one line of a 32-wide event bank, picked by a 5-bit select. Two instances can be chained through link ports to form one double-width channel. The lower instance drives the counter carry, the capture strobe and the counter clear. The upper instance follows them and holds the upper half of each timestamp.

Top module: `tstamp_capture`

## Requirements
- R1: The counter tick is picked by `tbase_sel`. Codes 0 to 4 use `tick_src[tbase_sel]`, and codes 5 to 7 advance the counter on every clock. With no clear active, the counter increments (wrapping at all-ones) in each cycle whose picked tick is high.
- R2: `edge_mode` codes are 1 any edge, 2 rising, 3 falling, 4 every 4th rising, 5 every 16th rising. Codes 0, 6 and 7 disable the channel. A disabled cycle leaves the counter at 0, the queue empty, `cap_overflow` low and `trig_status` low after the next edge. Reset gives the same state.
- R3: In codes 4 and 5, only the 4th (respectively 16th) rising edge since the mode was entered is captured, then counting restarts.
- R4: With `trig_mode`=1 the counter stays 0 while `trig_status` is low. A cycle with `evt_src[src_sel]` high sets `trig_status` at the next edge, and counting starts from the following cycle. Later events have no effect while the status is set.
- R5: A cycle with `status_clr` high in triggered mode clears `trig_status` and the counter at the next edge, and the counter is held again. The clear wins over a trigger event in the same cycle.
- R6: With `trig_mode`=0, a cycle with `evt_src[src_sel]` high leaves the counter at 0 after the next edge, and `trig_status` stays low.
- R7: A capture stores the counter value of the cycle in which the pin is first seen at its new level.
- R8: The queue holds 4 entries in arrival order, and `cap_data` shows the oldest one. `cap_pop` removes the head. A pop on an empty queue is ignored.
- R9: A capture that arrives while 4 entries are held (judged before any pop in the same cycle) is dropped. It sets `cap_overflow`, which stays set until the channel is disabled.
- R10: `irq` pulses for one cycle after a cycle in which a capture was stored and the occupancy became `irq_thresh`+1 (the field codes 0..3 mean 1..4 captures).
- R11: With `pair_upper`=1 the instance advances on `lnk_wrap_in`, is cleared by `lnk_clr_in` and captures on `lnk_cap_in`. Its stored value is therefore the upper half of the lower instance's counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Pin being timestamped |
| tick_src | input | 5 | Timer tick strobes |
| evt_src | input | N_SRC | Trigger/sync event bank |
| edge_mode | input | 3 | Capture edge mode, 0 disables |
| tbase_sel | input | 3 | Time base select |
| trig_mode | input | 1 | 1 triggered, 0 synchronized |
| src_sel | input | SRC_W | Event source index |
| irq_thresh | input | 2 | Captures per interrupt minus one |
| status_clr | input | 1 | Clear trigger status |
| cap_pop | input | 1 | Remove queue head |
| pair_upper | input | 1 | Act as upper half of a chained pair |
| lnk_clr_in | input | 1 | Counter clear from lower half |
| lnk_wrap_in | input | 1 | Counter carry from lower half |
| lnk_cap_in | input | 1 | Capture strobe from lower half |
| cap_data | output | CNT_W | Oldest stored timestamp |
| cap_level | output | LW | Queue occupancy |
| cap_overflow | output | 1 | Sticky dropped-capture flag |
| irq | output | 1 | Capture interrupt pulse |
| trig_status | output | 1 | Counter has been triggered |
| lnk_clr_out | output | 1 | This counter is cleared this cycle |
| lnk_wrap_out | output | 1 | This counter wraps this cycle |
| lnk_cap_out | output | 1 | Capture strobe this cycle |

## Verification
The assertions check, on every cycle, that the counter is zero while a triggered channel waits and after a sync event. They also check that the counter steps by exactly one on a tick and holds without one, that a disabled cycle empties the queue and clears the flags, that a capture into a full queue raises the sticky overflow flag, and that the interrupt and the trigger status only follow a store or an event. Only the bench's scenarios can show which values are captured and in what order. The same holds for the prescaled edge counts, the interrupt threshold codes, and the split of a timestamp across two chained instances. The bench's cycle model exposes all of these.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int TICK_N = 5;

  localparam logic [2:0] EM_OFF    = 3'd0;
  localparam logic [2:0] EM_ANY    = 3'd1;
  localparam logic [2:0] EM_RISE   = 3'd2;
  localparam logic [2:0] EM_FALL   = 3'd3;
  localparam logic [2:0] EM_RISE4  = 3'd4;
  localparam logic [2:0] EM_RISE16 = 3'd5;

  // channel is live only for the five defined edge codes
  function automatic logic mode_active(logic [2:0] m);
    return (m >= EM_ANY) && (m <= EM_RISE16);
  endfunction

  // last prescaler state before a capture; 0 means no prescaling
  function automatic logic [3:0] prescale_last(logic [2:0] m);
    if (m == EM_RISE4)  return 4'd3;
    if (m == EM_RISE16) return 4'd15;
    return 4'd0;
  endfunction

  function automatic logic tick_pick(logic [2:0] sel, logic [TICK_N-1:0] ticks);
    if (int'(sel) < TICK_N) return ticks[sel];
    return 1'b1;
  endfunction

  function automatic logic [2:0] irq_level(logic [1:0] thr);
    return {1'b0, thr} + 3'd1;
  endfunction
endpackage

// File: rtl/cap_edge.sv
module cap_edge
  import cap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [2:0] mode,
  output logic       cap_evt
);
  logic       pin_q;
  logic [3:0] pre_q;
  logic       rise, fall, divided;
  logic [3:0] last;

  assign rise    = pin & ~pin_q;
  assign fall    = ~pin & pin_q;
  assign last    = prescale_last(mode);
  assign divided = (last != 4'd0);

  always_comb begin
    case (mode)
      EM_ANY:             cap_evt = rise | fall;
      EM_RISE:            cap_evt = rise;
      EM_FALL:            cap_evt = fall;
      EM_RISE4, EM_RISE16: cap_evt = rise && (pre_q == last);
      default:            cap_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      pre_q <= '0;
    end else begin
      pin_q <= pin;
      if (!divided)  pre_q <= '0;
      else if (rise) pre_q <= (pre_q == last) ? 4'd0 : pre_q + 4'd1;
    end
  end
endmodule

// File: rtl/cap_timebase.sv
module cap_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             upper,
  input  logic             trig_mode,
  input  logic             tick,
  input  logic             evt,
  input  logic             status_clr,
  input  logic             lnk_clr_in,
  input  logic             lnk_wrap_in,
  output logic [CNT_W-1:0] cnt,
  output logic             trig_status,
  output logic             clr_out,
  output logic             wrap_out
);
  logic [CNT_W-1:0] cnt_q;
  logic             stat_q;
  logic             eff_tick, trig_hit, held, sync_hit, clr;

  assign eff_tick = upper ? lnk_wrap_in : tick;
  assign trig_hit = !upper && trig_mode && !stat_q && evt && !status_clr;
  assign held     = !upper && trig_mode && (!stat_q || status_clr);
  assign sync_hit = !upper && !trig_mode && evt;
  assign clr      = !enable || held || sync_hit || (upper && lnk_clr_in);

  assign wrap_out    = !clr && eff_tick && (&cnt_q);
  assign clr_out     = clr;
  assign cnt         = cnt_q;
  assign trig_status = stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (clr)           cnt_q <= '0;
      else if (eff_tick) cnt_q <= cnt_q + 1'b1;
      if (!enable || upper || !trig_mode) stat_q <= 1'b0;
      else if (status_clr)                stat_q <= 1'b0;
      else if (trig_hit)                  stat_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic [LW-1:0] level_next,
  output logic          full,
  output logic          stored,
  output logic          ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [LW-1:0] lvl_q;
  logic          ovf_q, do_push, do_pop;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (lvl_q == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (lvl_q != '0);
  assign stored  = do_push;
  assign level_next = lvl_q + LW'(do_push) - LW'(do_pop);
  assign head  = mem[rd_q];
  assign level = lvl_q;
  assign ovf   = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
      ovf_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wr_q] <= din;
        wr_q      <= bump(wr_q);
      end
      if (do_pop) rd_q <= bump(rd_q);
      lvl_q <= level_next;
      if (push && full) ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
  import cap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DEPTH  = 4,
  parameter int N_SRC  = 32,
  localparam int SRC_W = $clog2(N_SRC),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic [TICK_N-1:0] tick_src,
  input  logic [N_SRC-1:0]  evt_src,
  input  logic [2:0]        edge_mode,
  input  logic [2:0]        tbase_sel,
  input  logic              trig_mode,
  input  logic [SRC_W-1:0]  src_sel,
  input  logic [1:0]        irq_thresh,
  input  logic              status_clr,
  input  logic              cap_pop,
  input  logic              pair_upper,
  input  logic              lnk_clr_in,
  input  logic              lnk_wrap_in,
  input  logic              lnk_cap_in,
  output logic [CNT_W-1:0]  cap_data,
  output logic [LW-1:0]     cap_level,
  output logic              cap_overflow,
  output logic              irq,
  output logic              trig_status,
  output logic              lnk_clr_out,
  output logic              lnk_wrap_out,
  output logic              lnk_cap_out
);
  // named internal events, also observed by the checker
  logic             ch_enable, own_cap, cap_evt, sel_evt, tick_hit;
  logic             fifo_full, fifo_stored;
  logic [CNT_W-1:0] cnt_now;
  logic [LW-1:0]    level_next;
  logic             irq_q;

  assign ch_enable = mode_active(edge_mode);
  assign sel_evt   = evt_src[src_sel];
  assign tick_hit  = tick_pick(tbase_sel, tick_src);
  assign cap_evt   = ch_enable && (pair_upper ? lnk_cap_in : own_cap);
  assign lnk_cap_out = cap_evt;

  cap_edge u_edge (
    .clk(clk), .rst_n(rst_n), .pin(pin_in), .mode(edge_mode), .cap_evt(own_cap)
  );

  cap_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .enable(ch_enable), .upper(pair_upper),
    .trig_mode(trig_mode), .tick(tick_hit), .evt(sel_evt),
    .status_clr(status_clr), .lnk_clr_in(lnk_clr_in), .lnk_wrap_in(lnk_wrap_in),
    .cnt(cnt_now), .trig_status(trig_status),
    .clr_out(lnk_clr_out), .wrap_out(lnk_wrap_out)
  );

  cap_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!ch_enable), .push(cap_evt), .pop(cap_pop),
    .din(cnt_now), .head(cap_data), .level(cap_level), .level_next(level_next),
    .full(fifo_full), .stored(fifo_stored), .ovf(cap_overflow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= fifo_stored && (level_next == LW'(irq_level(irq_thresh)));
  end
  assign irq = irq_q;
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ch_enable,
  input logic             pair_upper,
  input logic             trig_mode,
  input logic             sel_evt,
  input logic             tick_hit,
  input logic             status_clr,
  input logic [CNT_W-1:0] cnt_now,
  input logic             trig_status,
  input logic [LW-1:0]    cap_level,
  input logic             cap_overflow,
  input logic             irq,
  input logic             cap_evt,
  input logic             fifo_full,
  input logic             fifo_stored
);
  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_level <= LW'(DEPTH));

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_enable && cap_evt && fifo_full) |=> cap_overflow);

  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_enable && cap_overflow) |=> cap_overflow);

  // R2
  off_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_enable |=> (cap_level == '0 && !cap_overflow && !trig_status && cnt_now == '0));

  // R4
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_enable && !pair_upper && trig_mode && !trig_status) |=> cnt_now == '0);

  // R4
  trig_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_status) |-> $past(sel_evt));

  // R5
  status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr |=> !trig_status);

  // R6
  sync_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_enable && !pair_upper && !trig_mode && sel_evt) |=> cnt_now == '0);

  // R1
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_enable && !pair_upper && !trig_mode && !sel_evt && tick_hit)
      |=> cnt_now == CNT_W'($past(cnt_now) + 1'b1));

  // R1
  tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_enable && !pair_upper && !trig_mode && !sel_evt && !tick_hit) |=> $stable(cnt_now));

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(fifo_stored));
endmodule

bind tstamp_capture cap_checker #(.CNT_W(CNT_W), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .pair_upper(pair_upper),
  .trig_mode(trig_mode), .sel_evt(sel_evt), .tick_hit(tick_hit),
  .status_clr(status_clr), .cnt_now(cnt_now), .trig_status(trig_status),
  .cap_level(cap_level), .cap_overflow(cap_overflow), .irq(irq),
  .cap_evt(cap_evt), .fifo_full(fifo_full), .fifo_stored(fifo_stored)
);

// File: tb/sim_tstamp_capture.sv
module sim_tstamp_capture;
  localparam int CW = 8;
  localparam int MOD = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        b_pin = 0, b_tmode = 0, b_sclr = 0, b_pop = 0;
  logic [4:0]  b_ticks = 0, b_sel = 0;
  logic [31:0] b_evt = 0;
  logic [2:0]  b_mode = 0, b_tb = 0, b_mode1 = 0;
  logic [1:0]  b_thr = 0;

  logic [CW-1:0] d0, d1;
  logic [2:0]    l0, l1;
  logic          ov0, ir0, st0, ov1, ir1, st1;
  logic          lclr, lwrap, lcap, xclr, xwrap, xcap;

  tstamp_capture #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(b_pin), .tick_src(b_ticks), .evt_src(b_evt),
    .edge_mode(b_mode), .tbase_sel(b_tb), .trig_mode(b_tmode), .src_sel(b_sel),
    .irq_thresh(b_thr), .status_clr(b_sclr), .cap_pop(b_pop), .pair_upper(1'b0),
    .lnk_clr_in(1'b0), .lnk_wrap_in(1'b0), .lnk_cap_in(1'b0),
    .cap_data(d0), .cap_level(l0), .cap_overflow(ov0), .irq(ir0), .trig_status(st0),
    .lnk_clr_out(lclr), .lnk_wrap_out(lwrap), .lnk_cap_out(lcap));

  tstamp_capture #(.CNT_W(CW)) u1 (
    .clk(clk), .rst_n(rst_n), .pin_in(1'b0), .tick_src(5'd0), .evt_src(32'd0),
    .edge_mode(b_mode1), .tbase_sel(3'd0), .trig_mode(1'b0), .src_sel(5'd0),
    .irq_thresh(2'd3), .status_clr(1'b0), .cap_pop(1'b0), .pair_upper(1'b1),
    .lnk_clr_in(lclr), .lnk_wrap_in(lwrap), .lnk_cap_in(lcap),
    .cap_data(d1), .cap_level(l1), .cap_overflow(ov1), .irq(ir1), .trig_status(st1),
    .lnk_clr_out(xclr), .lnk_wrap_out(xwrap), .lnk_cap_out(xcap));

  int    checks = 0, errors = 0;
  string cur_req = "R2";
  bit    done = 0;

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act %0d exp %0d", cur_req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model of u0 ----------------
  int m_cnt, m_full, m_pre, m_last_full;
  bit m_stat, m_ovf, m_irq, m_prev;
  int m_q[$];

  always @(posedge clk) begin : mdl
    bit rise, fall, cap, tk, ev, off, stored;
    int div, old;
    if (!rst_n) begin
      m_cnt = 0; m_full = 0; m_pre = 0; m_stat = 0; m_ovf = 0; m_irq = 0;
      m_prev = 0; m_q.delete();
    end else begin
      rise = b_pin && !m_prev;
      fall = !b_pin && m_prev;
      div  = (b_mode == 4) ? 4 : 16;
      case (b_mode)
        1: cap = rise || fall;
        2: cap = rise;
        3: cap = fall;
        4, 5: cap = rise && (m_pre == div - 1);
        default: cap = 0;
      endcase
      if (b_mode == 4 || b_mode == 5) begin
        if (rise) m_pre = (m_pre == div - 1) ? 0 : m_pre + 1;
      end else m_pre = 0;
      off = (b_mode == 0) || (b_mode > 5);
      tk  = (b_tb >= 5) ? 1'b1 : b_ticks[b_tb];
      ev  = b_evt[b_sel];
      if (off) begin
        m_q.delete(); m_ovf = 0; m_stat = 0; m_cnt = 0; m_full = 0; m_irq = 0;
      end else begin
        old = m_q.size();
        stored = 0;
        if (b_pop && old > 0) void'(m_q.pop_front());
        if (cap) begin
          if (old == 4) m_ovf = 1;
          else begin m_q.push_back(m_cnt); m_last_full = m_full; stored = 1; end
        end
        m_irq = stored && (m_q.size() == int'(b_thr) + 1);
        if (b_tmode) begin
          if (b_sclr) begin m_stat = 0; m_cnt = 0; m_full = 0; end
          else if (!m_stat) begin m_cnt = 0; m_full = 0; if (ev) m_stat = 1; end
          else if (tk) begin m_cnt = (m_cnt + 1) % MOD; m_full++; end
        end else begin
          m_stat = 0;
          if (ev) begin m_cnt = 0; m_full = 0; end
          else if (tk) begin m_cnt = (m_cnt + 1) % MOD; m_full++; end
        end
      end
      m_prev = b_pin;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("level", int'(l0), m_q.size());
      cmp("overflow", int'(ov0), int'(m_ovf));
      cmp("irq", int'(ir0), int'(m_irq));
      cmp("trig_status", int'(st0), int'(m_stat));
      if (m_q.size() > 0) cmp("head data", int'(d0), m_q[0]);
    end
  end

  // pseudo-random timer ticks
  initial begin : tickgen
    logic [15:0] lf = 16'hACE1;
    forever begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      b_ticks = lf[4:0];
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int hi, int lo);
    b_pin = 1; idle(hi);
    b_pin = 0; idle(lo);
  endtask

  task automatic go_off();
    b_mode = 0; b_mode1 = 0; b_pop = 0; b_sclr = 0; b_evt = 0;
    idle(1);
  endtask

  initial begin
    idle(3);
    cur_req = "R2";
    cmp("reset level", int'(l0), 0);
    cmp("reset overflow", int'(ov0), 0);
    cmp("reset trig_status", int'(st0), 0);
    cmp("reset irq", int'(ir0), 0);
    rst_n = 1;
    idle(2);

    // R1: each time base code, any-edge captures, popping between bursts
    cur_req = "R1";
    b_thr = 3; b_sel = 9; b_tmode = 0;
    for (int t = 0; t < 8; t++) begin
      go_off();
      b_tb = 3'(t); b_mode = 1;
      for (int k = 0; k < 3; k++) begin
        pulse(3 + k, 5);
        b_pop = 1; idle(2); b_pop = 0;
      end
    end

    // R7: rising-only and falling-only timestamps
    cur_req = "R7";
    go_off(); b_tb = 7; b_mode = 2; b_thr = 0;
    idle(7); pulse(4, 9); pulse(2, 3);
    b_pop = 1; idle(3); b_pop = 0;
    go_off(); b_mode = 3; b_tb = 1;
    idle(5); pulse(6, 4); pulse(1, 2);

    // R8: order of entries and pops on an empty queue
    cur_req = "R8";
    b_pop = 1; idle(6); b_pop = 0;
    b_mode = 1; pulse(2, 2); pulse(3, 1);
    b_pop = 1; idle(1); b_pop = 0; idle(2);
    b_pop = 1; idle(5); b_pop = 0;

    // R3: divided rising-edge modes
    cur_req = "R3";
    go_off(); b_tb = 7; b_mode = 4; b_pop = 1;
    for (int k = 0; k < 11; k++) pulse(1, 2);
    go_off(); b_mode = 5; b_pop = 1;
    for (int k = 0; k < 35; k++) pulse(1, 1);
    b_pop = 0;

    // R9: capture into a full queue is dropped and sticks the flag
    cur_req = "R9";
    go_off(); b_mode = 1;
    for (int k = 0; k < 4; k++) pulse(2, 2);
    b_pop = 1; idle(2); b_pop = 0;
    pulse(1, 3);
    b_pop = 1; idle(6); b_pop = 0;

    // R10: every threshold code
    cur_req = "R10";
    for (int t = 0; t < 4; t++) begin
      go_off(); b_thr = 2'(t); b_mode = 2;
      for (int k = 0; k < 5; k++) pulse(1, 2);
      b_pop = 1; idle(1); b_pop = 0; pulse(1, 2);
    end

    // R4: held until the chosen source fires; other sources ignored
    cur_req = "R4";
    go_off(); b_mode = 2; b_tmode = 1; b_sel = 9; b_tb = 7; b_thr = 3;
    idle(5); pulse(1, 2);
    b_evt = 32'h8; idle(1); b_evt = 0; idle(3);
    b_evt = 32'h200; idle(1); b_evt = 0; idle(6);
    pulse(1, 2);
    b_evt = 32'h200; idle(2); b_evt = 0;
    pulse(1, 2);
    b_pop = 1; idle(4); b_pop = 0;

    // R5: status clear returns to the held state, wins over a trigger
    cur_req = "R5";
    b_sclr = 1; idle(1); b_sclr = 0; idle(4);
    pulse(1, 2);
    b_sclr = 1; b_evt = 32'h200; idle(1); b_sclr = 0; b_evt = 0; idle(3);
    pulse(1, 2);
    b_evt = 32'h200; idle(1); b_evt = 0; idle(5);
    pulse(1, 2);
    b_pop = 1; idle(4); b_pop = 0;

    // R6: sync events clear the running counter
    cur_req = "R6";
    go_off(); b_tmode = 0; b_sel = 20; b_tb = 7; b_mode = 2; b_pop = 1;
    for (int k = 0; k < 6; k++) begin
      idle(3 + k);
      b_evt = 32'h0010_0000; idle(1); b_evt = 0;
      idle(k); pulse(1, 1);
    end
    b_evt = 32'h0010_0008; b_sel = 3; idle(1); b_evt = 0;
    b_pop = 0;

    // R11: chained pair, upper half holds the carry count
    cur_req = "R11";
    go_off(); idle(1);
    b_tb = 7; b_sel = 9; b_mode = 2; b_mode1 = 2;
    idle(300); pulse(1, 2);
    cmp("upper level", int'(l1), 1);
    cmp("upper half", int'(d1), (m_last_full / MOD) % MOD);
    cmp("lower half", int'(d0), m_last_full % MOD);
    idle(600); pulse(1, 2);
    cmp("upper level after second", int'(l1), 2);

    // R2: disabling mid-run flushes everything
    cur_req = "R2";
    b_mode = 1; pulse(2, 2); b_mode = 6; idle(2);
    cmp("disabled level", int'(l0), 0);
    b_mode = 2; idle(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule